// File: doc/BRIEF.md
# Packet to Bus Command Bridge

This block lets an external link reach an on-chip memory-mapped bus. A byte stream arrives through an input FIFO. The block collects a fixed 12-byte command frame from that stream and runs a single 32-bit read or write on the bus as master. It then answers with a 12-byte response frame on an output FIFO.

The frame opens with a start marker and carries a sequence marker, a command, a big-endian address and a big-endian data word. Every frame that is accepted gets exactly one answer. Failures set the top bit of the returned command byte: a bad sequence marker, an unknown command, or a bus that never acknowledges. The block waits for the whole answer to leave before it reads another byte.

Both FIFOs are first-word-fall-through. On the input side, `in_data` is valid whenever `in_empty` is low, and a byte is consumed on a clock edge where `in_rd` is high. On the output side, the FIFO takes `out_data` on a clock edge where `out_wr` is high.

Top module: `pkt_bus_bridge`

## Requirements
- R1: While it waits for frame byte 0, any input byte other than 0xDE is consumed and dropped, with no effect on the bus or the output. The byte 0xDE starts a frame of 12 bytes.
- R2: A frame whose byte 7 is 0xCA and whose command byte 1 is 0x02 produces one bus write. The address is bytes 2..5 and the data is bytes 8..11, most significant byte first in both.
- R3: A frame whose byte 7 is 0xCA and whose command byte 1 is 0x01 produces one bus read at address bytes 2..5. Bytes 8..11 of the response carry the `bus_rdata` value captured at the acknowledge, most significant byte first.
- R4: A bus strobe, with its address and write data, stays steady until a cycle in which `bus_ack` is high. The strobe is low in the next cycle, and `bus_rd` and `bus_wr` are never high together.
- R5: If `bus_ack` does not arrive, the strobe stays high for exactly 255 cycles and is then dropped. The response has bit 7 of byte 1 set and echoes the command data in bytes 8..11. An acknowledge in the 255th strobe cycle still counts as success.
- R6: A frame whose byte 7 is not 0xCA issues no bus cycle and is answered with bit 7 of byte 1 set.
- R7: A command byte other than 0x01 or 0x02 issues no bus cycle and is answered with bit 7 of byte 1 set.
- R8: Response bytes 0 and 2..7 repeat the command frame. Byte 1 is the command byte, OR 0x80 on error. Bytes 8..11 hold the read value after a successful read, and the command data otherwise.
- R9: Each accepted frame yields exactly 12 output writes, in byte order 0..11, and `out_wr` is never high while `out_full` is high.
- R10: After the 12th byte of a frame is consumed, `in_rd` stays low until the last response byte has been written.
- R11: A synchronous active-high reset drops both bus strobes and `out_wr`, abandons any partial frame or open bus cycle, and returns the parser to waiting for 0xDE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_empty | input | 1 | Input FIFO has no byte |
| in_rd | output | 1 | Consume the byte on `in_data` |
| in_data | input | 8 | Head byte of the input FIFO |
| out_full | input | 1 | Output FIFO cannot take a byte |
| out_wr | output | 1 | Write `out_data` into the output FIFO |
| out_data | output | 8 | Response byte |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, valid with `bus_ack` |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ack | input | 1 | Bus cycle acknowledge |

## Verification
Assertions check the following on every cycle:
- the bus handshake: strobes are exclusive, address and data are held while a strobe waits, and the strobe drops after an acknowledge;
- the timeout counter stays inside its window;
- input reads happen only while the controller is collecting a frame;
- bus strobes and output writes appear only in their own phase.

Other behaviour can only be shown by the bench's scenarios:
- the byte content of the responses, such as the error bit, the echo and the big-endian read value;
- hunting past junk bytes;
- the exact 255-cycle timeout edge;
- recovery after reset in the middle of a frame or of a bus cycle.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int ADDR_W      = 32;
  localparam int DATA_W      = 32;
  localparam int FRAME_BYTES = 12;
  localparam int FRAME_W     = FRAME_BYTES * 8;

  localparam logic [7:0] SOP_MARK = 8'hDE;
  localparam logic [7:0] SEQ_MARK = 8'hCA;
  localparam logic [7:0] OP_READ  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] ERR_FLAG = 8'h80;

  // Field order follows wire order: first byte in the top bits.
  typedef struct packed {
    logic [7:0]        sop;
    logic [7:0]        op;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        len;
    logic [7:0]        seq;
    logic [DATA_W-1:0] data;
  } frame_t;

  typedef enum logic [1:0] {CTL_RX, CTL_BUS, CTL_TX} ctl_state_t;
endpackage

// File: rtl/bridge_rx_parser.sv
module bridge_rx_parser
  import bridge_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               resume,
  input  logic               in_empty,
  output logic               in_rd,
  input  logic [7:0]         in_data,
  output logic               pkt_valid,
  output logic [FRAME_W-1:0] pkt_frame
);
  localparam int CNT_W = $clog2(FRAME_BYTES);

  logic             hold;
  logic [CNT_W-1:0] idx;
  logic [FRAME_W-1:0] shreg;

  assign in_rd     = ~hold & ~in_empty;
  assign pkt_frame = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= 1'b0;
      idx       <= '0;
      pkt_valid <= 1'b0;
      shreg     <= '0;
    end else begin
      pkt_valid <= 1'b0;
      if (resume) hold <= 1'b0;
      if (in_rd) begin
        if (idx == '0 && in_data != SOP_MARK) begin
          idx <= '0; // still hunting
        end else begin
          shreg <= {shreg[FRAME_W-9:0], in_data};
          if (idx == CNT_W'(FRAME_BYTES - 1)) begin
            idx       <= '0;
            hold      <= 1'b1;
            pkt_valid <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  // R10: a finished frame freezes the input until resumed
  assert_hold_after_frame_R10: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> !in_rd);
  // R1: a finished frame always began with the start marker
  assert_frame_starts_marked_R1: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> pkt_frame[FRAME_W-1 -: 8] == SOP_MARK);
endmodule

// File: rtl/bridge_bus_master.sv
module bridge_bus_master
  import bridge_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              done,
  output logic              timed_out,
  output logic [DATA_W-1:0] rdata
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic          active;
  logic [TW-1:0] wait_cnt;

  assign active = bus_rd | bus_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      rdata     <= '0;
      wait_cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        bus_addr  <= start_addr;
        bus_wdata <= start_wdata;
        bus_rd    <= ~start_wr;
        bus_wr    <= start_wr;
        wait_cnt  <= '0;
        timed_out <= 1'b0;
      end else if (active) begin
        if (bus_ack) begin
          bus_rd    <= 1'b0;
          bus_wr    <= 1'b0;
          done      <= 1'b1;
          timed_out <= 1'b0;
          if (bus_rd) rdata <= bus_rdata;
        end else if (wait_cnt == TW'(TIMEOUT_CYCLES - 1)) begin
          bus_rd    <= 1'b0;
          bus_wr    <= 1'b0;
          done      <= 1'b1;
          timed_out <= 1'b1;
        end else begin
          wait_cnt <= wait_cnt + 1'b1;
        end
      end
    end
  end

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_rd, bus_wr}));
  assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (active && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_wdata)));
  assert_drop_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (active && bus_ack) |=> !active);
  assert_wait_window_R5: assert property (@(posedge clk) disable iff (rst)
    active |-> wait_cnt < TW'(TIMEOUT_CYCLES));
endmodule

// File: rtl/bridge_tx_serializer.sv
module bridge_tx_serializer
  import bridge_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic               out_full,
  output logic               out_wr,
  output logic [7:0]         out_data,
  output logic               done
);
  localparam int CNT_W = $clog2(FRAME_BYTES);

  logic               active;
  logic [CNT_W-1:0]   idx;
  logic [FRAME_W-1:0] shreg;

  assign out_wr   = active & ~out_full;
  assign out_data = shreg[FRAME_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      shreg  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        shreg  <= frame;
        active <= 1'b1;
        idx    <= '0;
      end else if (out_wr) begin
        shreg <= {shreg[FRAME_W-9:0], 8'h00};
        if (idx == CNT_W'(FRAME_BYTES - 1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assert_byte_index_bound_R9: assert property (@(posedge clk) disable iff (rst)
    active |-> idx < CNT_W'(FRAME_BYTES));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/pkt_bus_bridge.sv
module pkt_bus_bridge
  import bridge_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 255
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_empty,
  output logic        in_rd,
  input  logic [7:0]  in_data,
  input  logic        out_full,
  output logic        out_wr,
  output logic [7:0]  out_data,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  output logic        bus_rd,
  output logic        bus_wr,
  input  logic        bus_ack
);
  ctl_state_t         state;
  frame_t             hdr;
  frame_t             resp;
  logic [FRAME_W-1:0] rx_frame;
  logic               pkt_valid;
  logic               bus_start;
  logic               bus_done;
  logic               bus_tmo;
  logic [DATA_W-1:0]  bus_rval;
  logic               tx_start;
  logic               tx_done;
  frame_t             rx_f;

  assign rx_f = frame_t'(rx_frame);

  bridge_rx_parser u_rx (
    .clk(clk), .rst(rst), .resume(tx_done),
    .in_empty(in_empty), .in_rd(in_rd), .in_data(in_data),
    .pkt_valid(pkt_valid), .pkt_frame(rx_frame)
  );

  bridge_bus_master #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_bus (
    .clk(clk), .rst(rst), .start(bus_start),
    .start_wr(hdr.op == OP_WRITE), .start_addr(hdr.addr), .start_wdata(hdr.data),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .done(bus_done), .timed_out(bus_tmo), .rdata(bus_rval)
  );

  bridge_tx_serializer u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .frame(resp),
    .out_full(out_full), .out_wr(out_wr), .out_data(out_data), .done(tx_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CTL_RX;
      hdr       <= '0;
      resp      <= '0;
      bus_start <= 1'b0;
      tx_start  <= 1'b0;
    end else begin
      bus_start <= 1'b0;
      tx_start  <= 1'b0;
      unique case (state)
        CTL_RX: if (pkt_valid) begin
          hdr <= rx_f;
          if (rx_f.seq == SEQ_MARK && (rx_f.op == OP_READ || rx_f.op == OP_WRITE)) begin
            bus_start <= 1'b1;
            state     <= CTL_BUS;
          end else begin
            resp      <= rx_f;
            resp.op   <= rx_f.op | ERR_FLAG;
            tx_start  <= 1'b1;
            state     <= CTL_TX;
          end
        end
        CTL_BUS: if (bus_done) begin
          resp     <= hdr;
          resp.op  <= bus_tmo ? (hdr.op | ERR_FLAG) : hdr.op;
          resp.data <= (!bus_tmo && hdr.op == OP_READ) ? bus_rval : hdr.data;
          tx_start <= 1'b1;
          state    <= CTL_TX;
        end
        CTL_TX: if (tx_done) state <= CTL_RX;
        default: state <= CTL_RX;
      endcase
    end
  end

  assert_read_only_collecting_R10: assert property (@(posedge clk) disable iff (rst)
    in_rd |-> state == CTL_RX);
  assert_strobe_in_bus_phase_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> state == CTL_BUS);
  assert_write_in_tx_phase_R9: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> (state == CTL_TX && !out_full));
endmodule

// File: tb/pkt_bus_bridge_test.sv
module pkt_bus_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;

  localparam logic [95:0] V_FRAME [NV] = '{
    96'hDE_02_12345678_04_CA_A1B2C3D4,
    96'hDE_01_0000100C_04_CA_00000000,
    96'hDE_02_AABBCCDD_04_CB_11223344,
    96'hDE_07_01020304_04_CA_55667788,
    96'hDE_01_FFFFFFFC_04_CA_00000000};
  localparam logic [7:0]  V_LAT   [NV] = '{8'd3, 8'd0, 8'd0, 8'd0, 8'd254};
  localparam logic [31:0] V_RDATA [NV] = '{32'h0, 32'hCAFEF00D, 32'h0, 32'h0, 32'h0BADBEEF};
  localparam logic [95:0] V_RESP  [NV] = '{
    96'hDE_02_12345678_04_CA_A1B2C3D4,
    96'hDE_01_0000100C_04_CA_CAFEF00D,
    96'hDE_82_AABBCCDD_04_CB_11223344,
    96'hDE_87_01020304_04_CA_55667788,
    96'hDE_01_FFFFFFFC_04_CA_0BADBEEF};
  localparam int V_NBUS [NV] = '{1, 1, 0, 0, 1};
  localparam string V_REQ [NV] = '{"R2", "R3", "R6", "R7", "R5"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_empty, in_rd, out_full, out_wr, bus_rd, bus_wr, bus_ack;
  logic [7:0] in_data, out_data;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  // input FIFO model
  logic [7:0] in_mem [256];
  logic [7:0] in_wp = 0;
  logic [7:0] in_rp = 0;
  int         pops = 0;
  // output capture
  logic [7:0] out_mem [256];
  int         out_cnt = 0;
  int         full_viol = 0;
  // bus slave
  logic [7:0]  ack_lat = 0;
  logic        ack_en = 1'b1;
  logic [7:0]  slave_cnt = 0;
  int          strb_cyc = 0;
  int          bus_cyc = 0;
  logic [31:0] log_addr = 0, log_wdata = 0;
  logic        log_wr = 0;
  // R10 monitor
  logic mon_en = 1'b0;
  int   pop_base = 0, out_base = 0, hold_viol = 0;
  logic bp_en = 1'b0;
  int   cyc = 0;

  assign in_empty  = (in_rp == in_wp);
  assign in_data   = in_mem[in_rp];
  assign bus_ack   = ack_en && (bus_rd || bus_wr) && (slave_cnt == ack_lat);

  pkt_bus_bridge uut (
    .clk(clk), .rst(rst), .in_empty(in_empty), .in_rd(in_rd), .in_data(in_data),
    .out_full(out_full), .out_wr(out_wr), .out_data(out_data),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack(bus_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) in_rp <= in_wp;
    else if (in_rd) begin in_rp <= in_rp + 1; pops <= pops + 1; end
    if (!rst && out_wr) begin
      out_mem[out_cnt[7:0]] <= out_data;
      out_cnt <= out_cnt + 1;
      if (out_full) full_viol <= full_viol + 1;
    end
    if (bus_rd || bus_wr) begin
      slave_cnt <= slave_cnt + 1;
      strb_cyc  <= strb_cyc + 1;
      if (bus_ack) begin
        bus_cyc <= bus_cyc + 1; log_addr <= bus_addr; log_wdata <= bus_wdata; log_wr <= bus_wr;
      end
    end else slave_cnt <= 0;
    if (mon_en && in_rd && (out_cnt - out_base) < ((pops - pop_base) / 12) * 12)
      hold_viol <= hold_viol + 1;
  end

  always @(negedge clk) out_full <= bp_en && (cyc % 3 != 0);

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_frame(input logic [95:0] f);
    for (int i = 0; i < 12; i++) push_byte(f[95 - 8*i -: 8]);
  endtask

  task automatic push_byte(input logic [7:0] b);
    in_mem[in_wp] = b;
    in_wp = in_wp + 1;
  endtask

  task automatic wait_out(input int target);
    int t = 0;
    while (out_cnt < target && t < 3000) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
  endtask

  function automatic logic [95:0] resp_at(input int base);
    logic [95:0] r;
    for (int i = 0; i < 12; i++) r[95 - 8*i -: 8] = out_mem[(base + i) % 256];
    return r;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int ob, bb, sb;
    in_mem[0] = 8'h00;
    bus_rdata = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", {93'd0, bus_rd, bus_wr, out_wr}, 96'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", {95'd0, in_rd}, 96'd0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      ob = out_cnt; bb = bus_cyc;
      ack_lat = V_LAT[v]; bus_rdata = V_RDATA[v];
      push_frame(V_FRAME[v]);
      wait_out(ob + 12);
      chk({V_REQ[v], " R8 response"}, resp_at(ob), V_RESP[v]);
      chk("R9 byte count", 96'(out_cnt - ob), 96'd12);
      chk({V_REQ[v], " bus cycles"}, 96'(bus_cyc - bb), 96'(V_NBUS[v]));
      if (V_NBUS[v] != 0) begin
        chk({V_REQ[v], " address"}, 96'(log_addr), 96'(V_FRAME[v][79:48]));
        chk({V_REQ[v], " direction"}, 96'(log_wr), 96'(V_FRAME[v][87:80] == 8'h02));
        if (V_FRAME[v][87:80] == 8'h02) chk("R2 wdata", 96'(log_wdata), 96'(V_FRAME[v][31:0]));
      end
    end

    // R5: no acknowledge at all
    ob = out_cnt; bb = bus_cyc; sb = strb_cyc; ack_en = 1'b0;
    push_frame(96'hDE_01_00000040_04_CA_DEADBEEF);
    wait_out(ob + 12);
    chk("R5 timeout response", resp_at(ob), 96'hDE_81_00000040_04_CA_DEADBEEF);
    chk("R5 strobe cycles", 96'(strb_cyc - sb), 96'd255);
    chk("R5 no ack", 96'(bus_cyc - bb), 96'd0);
    ack_en = 1'b1; ack_lat = 0;

    // R1: junk ahead of the start marker
    ob = out_cnt; bb = bus_cyc;
    push_byte(8'h11); push_byte(8'hCA); push_byte(8'h00);
    push_frame(96'hDE_02_00000008_04_CA_00000001);
    wait_out(ob + 12);
    chk("R1 hunt response", resp_at(ob), 96'hDE_02_00000008_04_CA_00000001);
    chk("R1 single response", 96'(out_cnt - ob), 96'd12);
    chk("R1 bus address", 96'(log_addr), 96'h8);
    chk("R1 one bus cycle", 96'(bus_cyc - bb), 96'd1);

    // R9/R10: back-to-back frames under output backpressure
    ob = out_cnt; out_base = out_cnt; pop_base = pops; mon_en = 1'b1; bp_en = 1'b1;
    ack_lat = 2; bus_rdata = 32'h01234567;
    push_frame(96'hDE_01_00000100_04_CA_00000000);
    push_frame(96'hDE_02_00000104_04_CA_89ABCDEF);
    wait_out(ob + 24);
    bp_en = 1'b0; mon_en = 1'b0;
    @(negedge clk);
    chk("R9 first under backpressure", resp_at(ob), 96'hDE_01_00000100_04_CA_01234567);
    chk("R9 second under backpressure", resp_at(ob + 12), 96'hDE_02_00000104_04_CA_89ABCDEF);
    chk("R9 no write while full", 96'(full_viol), 96'd0);
    chk("R10 no read while responding", 96'(hold_viol), 96'd0);

    // R11: reset during a partial frame
    ob = out_cnt;
    for (int i = 0; i < 6; i++) push_byte(8'hDE + 8'(i));
    repeat (20) @(negedge clk);
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    push_frame(96'hDE_02_00000200_04_CA_0000ABCD);
    wait_out(ob + 12);
    chk("R11 partial frame dropped", resp_at(ob), 96'hDE_02_00000200_04_CA_0000ABCD);
    chk("R11 partial frame count", 96'(out_cnt - ob), 96'd12);

    // R11: reset during an open bus cycle
    ob = out_cnt; ack_en = 1'b0;
    push_frame(96'hDE_01_00000300_04_CA_00000000);
    repeat (40) @(negedge clk);
    chk("R4 strobe held without ack", 96'(bus_rd), 96'd1);
    rst = 1'b1; @(negedge clk);
    chk("R11 strobes cleared", {94'd0, bus_rd, bus_wr}, 96'd0);
    rst = 1'b0; ack_en = 1'b1;
    repeat (300) @(negedge clk);
    chk("R11 abandoned cycle unanswered", 96'(out_cnt - ob), 96'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule